// File: doc/BRIEF.md
# Status-Read Interrupt Release Handshake

This block drives the active-low interrupt request line of a serial-slave register port and controls when that line is released and raised again while the host reads the interrupt status word. Each interrupt source delivers single-cycle event pulses, which set a sticky pending flag. A per-source enable mask decides which pending flags may pull the request line low.

The host reads the status in two steps inside one chip-select window. It first sends a one-byte read command and then clocks out a 16-bit status word. At the last command edge the block copies the pending flags into its output shifter, clears the flags it copied, and lets the request line go high. The line stays high for the whole data phase. When the last status bit has gone out, the line is evaluated again. Any event that arrived in the meantime is still pending at that point and pulls the line low again, so no event is lost. Serial clock, chip select and data in are brought into the system clock domain, and the serial clock must run at no more than a quarter of the system clock rate.

Top module: `irq_status_handshake`

## Requirements
- R1: After reset the request line `irq_n_o` is high, `spi_miso_o` is low and no flag is pending, so a status read returns 0x0000.
- R2: An event pulse on source i sets pending flag i. The flag stays set while its enable is off, and it clears only when a status read captures it.
- R3: Outside a status-data phase, `irq_n_o` is low on the system clock after any pending flag whose enable bit is 1 is set, and it is high while no enabled flag is pending. Masked flags never pull it low.
- R4: The command byte is taken MSB first from `spi_mosi_i` on falling `spi_sclk_i` edges while `spi_cs_n_i` is low. If it equals 0x05, the status word is captured and `irq_n_o` goes high on the third system clock edge after the eighth falling edge. Before that edge the line is unchanged.
- R5: During the status-data phase `irq_n_o` stays high, even when new events arrive.
- R6: The status word is 16 bits, with source i in bit i and the upper bits zero. It is sent MSB first, and `spi_miso_o` changes only after rising serial-clock edges. Events after the capture do not alter the word being sent.
- R7: Capture clears exactly the captured flags. An event in the same system cycle as the capture is not in the word and stays pending.
- R8: After the sixteenth falling edge of the data phase, `irq_n_o` is re-evaluated. It goes low if an enabled flag is pending and stays high otherwise.
- R9: Chip select going high ends any transfer at once: the hold is dropped, `irq_n_o` is re-evaluated per R3 and `spi_miso_o` returns low.
- R10: A command byte other than 0x05 captures nothing, clears nothing and leaves `irq_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | N_SRC | Per-source single-cycle event pulses |
| irq_enable_i | input | N_SRC | Per-source enable mask for the request line |
| spi_cs_n_i | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The capture-and-clear at the end of the command byte can fall in the same system cycle as a new event pulse. This is the collision that decides whether an event can be lost. The bench provokes it by timing two source pulses from the last falling serial-clock edge, one cycle before the capture and exactly on the capture cycle. It then judges the result three ways: the earlier source must appear in the word read out, the later source must be missing from it, and the later source must pull the line low again after the data phase and then appear in the next read.

// File: rtl/irq_hs_pkg.sv
package irq_hs_pkg;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/irq_hs_sync.sv
module irq_hs_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_hs_serial.sv
module irq_hs_serial
   import irq_hs_pkg::*;
#(
   parameter int               CMD_W     = 8,
   parameter int               STAT_W    = 16,
   parameter logic [CMD_W-1:0] READ_CODE = 'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic [STAT_W-1:0] status_word,
   output logic              rise_o,
   output logic              cap_o,
   output logic              hold_o,
   output logic              hold_d_o,
   output logic              miso_o
);

   localparam int CNT_W = $clog2(max2(CMD_W, STAT_W));

   phase_e              phase_q, phase_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic [CMD_W-1:0]    cmd_q, cmd_d, cmd_next;
   logic [STAT_W-1:0]   shf_q, shf_d;
   logic                miso_q, miso_d;
   logic                hold_q, hold_d;
   logic                sclk_prev_q;
   logic                rise, fall, cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev_q <= 1'b0;
      else        sclk_prev_q <= sclk_s;
   end

   assign rise     = ~cs_n_s &  sclk_s & ~sclk_prev_q;
   assign fall     = ~cs_n_s & ~sclk_s &  sclk_prev_q;
   assign cmd_next = {cmd_q[CMD_W-2:0], mosi_s};

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      cmd_d   = cmd_q;
      shf_d   = shf_q;
      miso_d  = miso_q;
      hold_d  = hold_q;
      cap     = 1'b0;
      if (cs_n_s) begin
         phase_d = PH_CMD;
         cnt_d   = '0;
         hold_d  = 1'b0;
         miso_d  = 1'b0;
      end else begin
         unique case (phase_q)
            PH_CMD: begin
               if (fall) begin
                  cmd_d = cmd_next;
                  cnt_d = cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(CMD_W - 1)) begin
                     cnt_d = '0;
                     if (cmd_next == READ_CODE) begin
                        cap     = 1'b1;
                        phase_d = PH_DATA;
                        hold_d  = 1'b1;
                        shf_d   = status_word;
                     end else begin
                        phase_d = PH_DONE;
                     end
                  end
               end
            end
            PH_DATA: begin
               if (rise) begin
                  miso_d = shf_q[STAT_W-1];
                  shf_d  = {shf_q[STAT_W-2:0], 1'b0};
               end
               if (fall) begin
                  cnt_d = cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(STAT_W - 1)) begin
                     phase_d = PH_DONE;
                     hold_d  = 1'b0;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         cnt_q   <= '0;
         cmd_q   <= '0;
         shf_q   <= '0;
         miso_q  <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         cmd_q   <= cmd_d;
         shf_q   <= shf_d;
         miso_q  <= miso_d;
         hold_q  <= hold_d;
      end
   end

   assign rise_o   = rise;
   assign cap_o    = cap;
   assign hold_o   = hold_q;
   assign hold_d_o = hold_d;
   assign miso_o   = miso_q;

endmodule

// File: rtl/irq_hs_pending.sv
module irq_hs_pending #(
   parameter int N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] event_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic             cap_i,
   input  logic             hold_d_i,
   output logic [N_SRC-1:0] pend_o,
   output logic             irq_n_o
);

   logic [N_SRC-1:0] pend_q, pend_d;
   logic             irq_n_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_flag
      assign pend_d[i] = cap_i ? event_i[i] : (pend_q[i] | event_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= pend_d[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= hold_d_i | ~(|(pend_d & en_i));
   end

   assign pend_o  = pend_q;
   assign irq_n_o = irq_n_q;

endmodule

// File: rtl/irq_status_handshake.sv
module irq_status_handshake #(
   parameter int               N_SRC       = 6,
   parameter int               STAT_W      = 16,
   parameter int               CMD_W       = 8,
   parameter logic [CMD_W-1:0] READ_CODE   = 'h05,
   parameter int               SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] event_i,
   input  logic [N_SRC-1:0] irq_enable_i,
   input  logic             spi_cs_n_i,
   input  logic             spi_sclk_i,
   input  logic             spi_mosi_i,
   output logic             spi_miso_o,
   output logic             irq_n_o
);

   if (N_SRC < 1 || N_SRC > STAT_W) begin : g_bad_src
      $error("N_SRC must lie between 1 and STAT_W");
   end
   if (CMD_W < 2 || STAT_W < 2) begin : g_bad_width
      $error("CMD_W and STAT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]        bus_s;
   logic              cs_n_s, sclk_s, mosi_s;
   logic              sclk_rise, cap_stb, hold_q, hold_d;
   logic [N_SRC-1:0]  pend_q;
   logic [STAT_W-1:0] status_word;

   irq_hs_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_cs_n_i, spi_sclk_i, spi_mosi_i}),
      .q_o   (bus_s)
   );

   assign {cs_n_s, sclk_s, mosi_s} = bus_s;
   assign status_word = STAT_W'(pend_q);

   irq_hs_serial #(
      .CMD_W     (CMD_W),
      .STAT_W    (STAT_W),
      .READ_CODE (READ_CODE)
   ) i_serial (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (cs_n_s),
      .sclk_s      (sclk_s),
      .mosi_s      (mosi_s),
      .status_word (status_word),
      .rise_o      (sclk_rise),
      .cap_o       (cap_stb),
      .hold_o      (hold_q),
      .hold_d_o    (hold_d),
      .miso_o      (spi_miso_o)
   );

   irq_hs_pending #(
      .N_SRC (N_SRC)
   ) i_pending (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (event_i),
      .en_i     (irq_enable_i),
      .cap_i    (cap_stb),
      .hold_d_i (hold_d),
      .pend_o   (pend_q),
      .irq_n_o  (irq_n_o)
   );

endmodule

// File: rtl/irq_status_handshake_chk.sv
module irq_status_handshake_chk #(
   parameter int N_SRC = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_n,
   input logic             miso,
   input logic             hold,
   input logic             cap,
   input logic             rise,
   input logic             cs_hi,
   input logic [N_SRC-1:0] pend
);

   a_r4_capture_releases: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> irq_n);

   a_r5_hold_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> irq_n);

   a_r2_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap) |-> ((pend & $past(pend)) == $past(pend)));

   a_r6_miso_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold) && !$past(rise) && !$past(cs_hi)) |-> $stable(miso));

   a_r9_abort_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !hold);

endmodule

bind irq_status_handshake irq_status_handshake_chk #(.N_SRC(N_SRC)) i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .irq_n (irq_n_o),
   .miso  (spi_miso_o),
   .hold  (hold_q),
   .cap   (cap_stb),
   .rise  (sclk_rise),
   .cs_hi (cs_n_s),
   .pend  (pend_q)
);

// File: tb/test_irq_status_handshake.sv
module test_irq_status_handshake;

   localparam int NS   = 6;
   localparam int SW   = 16;
   localparam int HALF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] ev = '0;
   logic [NS-1:0] en = '1;
   logic          cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   wire           miso, irq_n;

   int vectors = 0;
   int miscomp = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   irq_status_handshake i_irq_status_handshake (
      .clk          (clk),
      .rst_n        (rst_n),
      .event_i      (ev),
      .irq_enable_i (en),
      .spi_cs_n_i   (cs_n),
      .spi_sclk_i   (sclk),
      .spi_mosi_i   (mosi),
      .spi_miso_o   (miso),
      .irq_n_o      (irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int src);
      @(negedge clk) ev[src] = 1'b1;
      @(negedge clk) ev = '0;
   endtask

   // One chip-select window: command byte, then (for a read) 16 data bits.
   task automatic status_read(input logic [7:0] cmd, input logic pre_irq, input logic post_irq,
                              input int coll_a, input int coll_b, input int inj_bit,
                              input int inj_src, input int abort_bit,
                              output logic [SW-1:0] word);
      bit aborted = 1'b0;
      word = '0;
      @(negedge clk) cs_n = 1'b0;
      idle(HALF);
      for (int i = 7; i >= 0; i--) begin
         mosi = cmd[i];
         sclk = 1'b1;
         idle(HALF);
         if (i == 0) chk("R4 line unchanged before last command edge", irq_n, pre_irq);
         sclk = 1'b0;
         if (i == 0 && coll_a >= 0) begin
            idle(1); ev[coll_b] = 1'b1;
            idle(1); ev = '0; ev[coll_a] = 1'b1;
            idle(1); ev = '0;
            idle(HALF - 3);
         end else begin
            idle(HALF);
         end
      end
      if (cmd != 8'h05) begin
         chk("R10 other command leaves line", irq_n, pre_irq);
      end else begin
         chk("R4 line released after command", irq_n, 1'b1);
         for (int b = 0; b < SW; b++) begin
            mosi = 1'b0;
            sclk = 1'b1;
            idle(HALF);
            word = {word[SW-2:0], miso};
            if (b == inj_bit) begin
               ev[inj_src] = 1'b1; idle(1); ev = '0;
            end
            chk("R5 line held high in data phase", irq_n, 1'b1);
            if (b == abort_bit) begin
               cs_n = 1'b1; sclk = 1'b0;
               idle(HALF);
               chk("R9 abort re-evaluates line", irq_n, post_irq);
               chk("R9 abort returns data low", miso, 1'b0);
               aborted = 1'b1;
               break;
            end
            sclk = 1'b0;
            idle(HALF);
         end
         if (!aborted) chk("R8 line after last status bit", irq_n, post_irq);
      end
      cs_n = 1'b1;
      idle(HALF);
   endtask

   task automatic t_reset();
      logic [SW-1:0] w;
      chk("R1 reset line high", irq_n, 1'b1);
      chk("R1 reset data low", miso, 1'b0);
      status_read(8'h05, 1'b1, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R1 empty status after reset", w, 16'h0000);
   endtask

   task automatic t_mask();
      en = '0;
      pulse(2);
      chk("R3 masked flag leaves line high", irq_n, 1'b1);
      idle(3);
      en = '1;
      idle(1);
      chk("R2 R3 flag kept while masked asserts on enable", irq_n, 1'b0);
   endtask

   task automatic t_basic();
      logic [SW-1:0] w;
      pulse(0);
      chk("R3 line low with pending", irq_n, 1'b0);
      status_read(8'h05, 1'b0, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R6 status word bits 0 and 2", w, 16'h0005);
      chk("R7 captured flags cleared, line high", irq_n, 1'b1);
   endtask

   task automatic t_event_in_data();
      logic [SW-1:0] w;
      pulse(1);
      status_read(8'h05, 1'b0, 1'b0, -1, 0, 5, 3, -1, w);
      chk("R6 word unaffected by later event", w, 16'h0002);
      status_read(8'h05, 1'b0, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R8 event during data re-signalled", w, 16'h0008);
   endtask

   task automatic t_collision();
      logic [SW-1:0] w;
      status_read(8'h05, 1'b1, 1'b0, 4, 5, -1, 0, -1, w);
      chk("R7 earlier event captured, same-cycle not", w, 16'h0020);
      status_read(8'h05, 1'b0, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R7 same-cycle event kept pending", w, 16'h0010);
   endtask

   task automatic t_abort();
      logic [SW-1:0] w;
      pulse(0);
      status_read(8'h05, 1'b0, 1'b0, -1, 0, 1, 2, 3, w);
      status_read(8'h05, 1'b0, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R9 flag from aborted window survives", w, 16'h0004);
   endtask

   task automatic t_other_cmd();
      logic [SW-1:0] w;
      pulse(3);
      status_read(8'h0A, 1'b0, 1'b0, -1, 0, -1, 0, -1, w);
      chk("R10 line still low after other command", irq_n, 1'b0);
      status_read(8'h05, 1'b0, 1'b1, -1, 0, -1, 0, -1, w);
      chk("R10 flag not cleared by other command", w, 16'h0008);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_mask();
      t_basic();
      t_event_in_data();
      t_collision();
      t_abort();
      t_other_cmd();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         miscomp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

endmodule